// File: doc/BRIEF.md
# Single-Pin Bus Master with Reset, Byte Write and Byte Read

This block is the master side of a single-wire open-drain serial bus. A host picks one of three operations with a two-bit command code and a one-cycle start strobe. The operations are a bus reset with presence detection, an eight-bit write, and an eight-bit read. The block then produces the timed low pulses on the wire. While it works it raises a busy flag. When it finishes it gives a one-cycle done pulse, together with the received byte or the presence result.

The block drives the wire only through an output-enable. When the enable is asserted the pad pulls the wire low. When it is clear the wire floats and an external pull-up returns it high. The wire is read back through a synchronizer. A prescaler divides the system clock by `CLK_MHZ` to make a one-microsecond tick, and every slot length is counted in these ticks. The prescaler restarts when a command is accepted, so the first interval of each command is a full microsecond.

Presence detection is done by polling, not by one fixed sample. The block checks the wire every 5 µs, first waiting for a slave to pull it low and then waiting for the wire to come back high. Each of these two phases has its own limit on the number of checks.

Top module: `ow_master`

## Requirements
- R1: Command code 00 (reset) asserts `bus_oe_o` for exactly 500 µs (`RST_LOW_US`). The block never asserts `bus_oe_o` while `busy_o` is low.
- R2: After the reset pulse the synchronized wire is checked every 5 µs, up to 100 checks. If the wire is never seen low, `present_o` is 0 and `done_o` rises exactly 1000 µs after the start was accepted.
- R3: Once the wire has been seen low, it is checked every 5 µs, up to 160 checks, for a return to high. `present_o` is 1 only if that return is seen within the window. A wire held low past the window gives 0.
- R4: Command code 01 (write) sends `wdata_i` in eight slots, least significant bit first. A 0 bit is 60 µs low then 5 µs released. A 1 bit is 5 µs low then 60 µs released. Every slot spans 65 µs from one falling edge to the next.
- R5: Command code 10 (read) runs eight slots, each 5 µs low and 70 µs long. The wire is sampled 10 µs after the slot starts. The first sampled bit ends up in `rdata_o[0]`.
- R6: `busy_o` rises on the cycle after an accepted start and falls in the cycle `done_o` is high. A start while busy, or a start with code 11, has no effect.
- R7: `done_o` is high for exactly one cycle per command. `rdata_o` changes only at the end of a read and `present_o` only at the end of a reset. A write leaves both unchanged.
- R8: After `rst_n` the block is idle: `busy_o`, `done_o`, `bus_oe_o`, `present_o` and `rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 00 reset, 01 write, 10 read, 11 ignored |
| wdata_i | input | 8 | Byte to send, captured when a write starts |
| start_i | input | 1 | One-cycle command strobe |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| rdata_o | output | 8 | Last byte read |
| present_o | output | 1 | Result of the last presence detection |
| bus_oe_o | output | 1 | 1 pulls the wire low, 0 releases it |
| bus_i | input | 1 | Asynchronous wire level |

## Verification
A bad phase counter or bad state shows up on `bus_oe_o` within the slot it affects. The low time or the falling-edge spacing changes by a whole number of microseconds, and the bench measures both to the exact cycle. A wrong shift direction or a stuck sampling point leaves the byte wrong at the end of the command, eight slots later. A miscounted poll limit either moves the done pulse of an absent-slave reset away from its exact cycle or flips `present_o` for a slave that answers near the edge of the window.

// File: rtl/ow_pkg.sv
package ow_pkg;

   typedef enum logic [1:0] {
      OW_CMD_RESET = 2'b00,
      OW_CMD_WRITE = 2'b01,
      OW_CMD_READ  = 2'b10,
      OW_CMD_NONE  = 2'b11
   } ow_cmd_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RST_LOW,
      S_PRES_LO,
      S_PRES_HI,
      S_WR_LOW,
      S_WR_REL,
      S_RD_LOW,
      S_RD_SAMP,
      S_RD_TAIL
   } ow_state_e;

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
   parameter int DIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cnt <= '0;
            else if (clr_i)                  cnt <= '0;
            else if (cnt == CW'(DIV - 1))    cnt <= '0;
            else                             cnt <= cnt + CW'(1);
         end
         assign tick_o = (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] sr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], d_i};
   end
   assign q_o = sr[STAGES-1];
endmodule

// File: rtl/ow_seq.sv
module ow_seq
   import ow_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int TW              = 10,
   parameter int RST_LOW_US      = 500,
   parameter int POLL_US         = 5,
   parameter int PRES_LO_POLLS   = 100,
   parameter int PRES_HI_POLLS   = 160,
   parameter int WR0_LOW_US      = 60,
   parameter int WR1_LOW_US      = 5,
   parameter int WR_RECOV_US     = 5,
   parameter int RD_LOW_US       = 5,
   parameter int RD_SAMPLE_US    = 5,
   parameter int RD_TAIL_US      = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              line_i,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              start_i,
   output logic              tick_clr_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              present_o,
   output logic              oe_o
);
   localparam int WR1_REL_US = WR0_LOW_US + WR_RECOV_US - WR1_LOW_US;
   localparam int POLL_MAX   = (PRES_LO_POLLS > PRES_HI_POLLS) ? PRES_LO_POLLS : PRES_HI_POLLS;
   localparam int PW         = $clog2(POLL_MAX + 1);
   localparam int BW         = $clog2(DATA_W);

   ow_state_e         state;
   logic [TW-1:0]     tmr;
   logic [PW-1:0]     polls;
   logic [BW-1:0]     bitn;
   logic [DATA_W-1:0] shreg;
   logic              accept, expire, last_bit;

   assign accept     = start_i && (state == S_IDLE) && (cmd_i != OW_CMD_NONE);
   assign expire     = tick_i && (tmr == TW'(1));
   assign last_bit   = (bitn == BW'(DATA_W - 1));
   assign tick_clr_o = accept;
   assign busy_o     = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         tmr       <= '0;
         polls     <= '0;
         bitn      <= '0;
         shreg     <= '0;
         done_o    <= 1'b0;
         rdata_o   <= '0;
         present_o <= 1'b0;
         oe_o      <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i && tmr != '0) tmr <= tmr - TW'(1);
         case (state)
            S_IDLE: if (accept) begin
               bitn  <= '0;
               polls <= '0;
               oe_o  <= 1'b1;
               case (cmd_i)
                  OW_CMD_RESET: begin
                     tmr   <= TW'(RST_LOW_US);
                     state <= S_RST_LOW;
                  end
                  OW_CMD_WRITE: begin
                     shreg <= wdata_i;
                     tmr   <= wdata_i[0] ? TW'(WR1_LOW_US) : TW'(WR0_LOW_US);
                     state <= S_WR_LOW;
                  end
                  default: begin
                     shreg <= '0;
                     tmr   <= TW'(RD_LOW_US);
                     state <= S_RD_LOW;
                  end
               endcase
            end
            S_RST_LOW: if (expire) begin
               oe_o  <= 1'b0;
               tmr   <= TW'(POLL_US);
               state <= S_PRES_LO;
            end
            S_PRES_LO: if (expire) begin
               if (!line_i) begin
                  polls <= '0;
                  tmr   <= TW'(POLL_US);
                  state <= S_PRES_HI;
               end else if (polls == PW'(PRES_LO_POLLS - 1)) begin
                  present_o <= 1'b0;
                  done_o    <= 1'b1;
                  state     <= S_IDLE;
               end else begin
                  polls <= polls + PW'(1);
                  tmr   <= TW'(POLL_US);
               end
            end
            S_PRES_HI: if (expire) begin
               if (line_i || polls == PW'(PRES_HI_POLLS - 1)) begin
                  present_o <= line_i;
                  done_o    <= 1'b1;
                  state     <= S_IDLE;
               end else begin
                  polls <= polls + PW'(1);
                  tmr   <= TW'(POLL_US);
               end
            end
            S_WR_LOW: if (expire) begin
               oe_o  <= 1'b0;
               tmr   <= shreg[0] ? TW'(WR1_REL_US) : TW'(WR_RECOV_US);
               state <= S_WR_REL;
            end
            S_WR_REL: if (expire) begin
               if (last_bit) begin
                  done_o <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  bitn  <= bitn + BW'(1);
                  shreg <= shreg >> 1;
                  oe_o  <= 1'b1;
                  tmr   <= shreg[1] ? TW'(WR1_LOW_US) : TW'(WR0_LOW_US);
                  state <= S_WR_LOW;
               end
            end
            S_RD_LOW: if (expire) begin
               oe_o  <= 1'b0;
               tmr   <= TW'(RD_SAMPLE_US);
               state <= S_RD_SAMP;
            end
            S_RD_SAMP: if (expire) begin
               shreg <= {line_i, shreg[DATA_W-1:1]};
               tmr   <= TW'(RD_TAIL_US);
               state <= S_RD_TAIL;
            end
            S_RD_TAIL: if (expire) begin
               if (last_bit) begin
                  rdata_o <= shreg;
                  done_o  <= 1'b1;
                  state   <= S_IDLE;
               end else begin
                  bitn  <= bitn + BW'(1);
                  oe_o  <= 1'b1;
                  tmr   <= TW'(RD_LOW_US);
                  state <= S_RD_LOW;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ow_master.sv
module ow_master #(
   parameter int CLK_MHZ       = 125,
   parameter int SYNC_STAGES   = 2,
   parameter int DATA_W        = 8,
   parameter int RST_LOW_US    = 500,
   parameter int POLL_US       = 5,
   parameter int PRES_LO_POLLS = 100,
   parameter int PRES_HI_POLLS = 160,
   parameter int WR0_LOW_US    = 60,
   parameter int WR1_LOW_US    = 5,
   parameter int WR_RECOV_US   = 5,
   parameter int RD_LOW_US     = 5,
   parameter int RD_SAMPLE_US  = 5,
   parameter int RD_TAIL_US    = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              present_o,
   output logic              bus_oe_o,
   input  logic              bus_i
);
   localparam int T_MAX = RST_LOW_US + WR0_LOW_US + WR_RECOV_US + RD_TAIL_US + POLL_US;
   localparam int TW    = $clog2(T_MAX + 1);

   generate
      if (CLK_MHZ < 1 || SYNC_STAGES < 2 || DATA_W < 2 || POLL_US < 1 ||
          WR1_LOW_US < 1 || WR1_LOW_US >= WR0_LOW_US || WR_RECOV_US < 1 ||
          RD_LOW_US < 1 || RD_SAMPLE_US < 1 || RD_TAIL_US < 1 ||
          PRES_LO_POLLS < 1 || PRES_HI_POLLS < 1 || RST_LOW_US < 1) begin : g_bad_cfg
         $error("ow_master: illegal parameter set");
      end
   endgenerate

   logic tick, tick_clr, line_s;

   ow_us_tick #(.DIV(CLK_MHZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr_i(tick_clr), .tick_o(tick)
   );

   ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(line_s)
   );

   ow_seq #(
      .DATA_W(DATA_W), .TW(TW), .RST_LOW_US(RST_LOW_US), .POLL_US(POLL_US),
      .PRES_LO_POLLS(PRES_LO_POLLS), .PRES_HI_POLLS(PRES_HI_POLLS),
      .WR0_LOW_US(WR0_LOW_US), .WR1_LOW_US(WR1_LOW_US), .WR_RECOV_US(WR_RECOV_US),
      .RD_LOW_US(RD_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .RD_TAIL_US(RD_TAIL_US)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line_s),
      .cmd_i(cmd_i), .wdata_i(wdata_i), .start_i(start_i),
      .tick_clr_o(tick_clr), .busy_o(busy_o), .done_o(done_o),
      .rdata_o(rdata_o), .present_o(present_o), .oe_o(bus_oe_o)
   );
endmodule

// File: rtl/ow_master_chk.sv
module ow_master_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [1:0]        cmd_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              present_o,
   input logic              bus_oe_o
);
   a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_oe_o);

   a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r6_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && cmd_i != 2'b11) |=> busy_o);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_o) |-> done_o);

   a_r7_present_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(present_o) |-> done_o);
endmodule

bind ow_master ow_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
   .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
   .present_o(present_o), .bus_oe_o(bus_oe_o)
);

// File: tb/ow_master_tb.sv
module ow_master_tb_top;
   localparam int CLK = 2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  byt;
      logic        has;
      logic [11:0] pd;
      logic [11:0] pl;
      logic        exp;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'h00, 1'b1, 12'd30,  12'd120,  1'b1},
      '{2'd0, 8'h00, 1'b0, 12'd0,   12'd0,    1'b0},
      '{2'd0, 8'h00, 1'b1, 12'd30,  12'd1000, 1'b0},
      '{2'd0, 8'h00, 1'b1, 12'd600, 12'd60,   1'b0},
      '{2'd0, 8'h00, 1'b1, 12'd490, 12'd60,   1'b1},
      '{2'd1, 8'hA5, 1'b0, 12'd0,   12'd0,    1'b0},
      '{2'd1, 8'h01, 1'b0, 12'd0,   12'd0,    1'b0},
      '{2'd2, 8'h3C, 1'b0, 12'd0,   12'd0,    1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b11;
   logic [7:0] wdata = '0;
   logic       start = 1'b0;
   logic       busy, done, present, oe;
   logic [7:0] rdata;
   logic       slave_pull = 1'b0;
   wire        line = !(oe || slave_pull);

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ow_master #(.CLK_MHZ(CLK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .wdata_i(wdata), .start_i(start),
      .busy_o(busy), .done_o(done), .rdata_o(rdata), .present_o(present),
      .bus_oe_o(oe), .bus_i(line)
   );

   // slave model and wire monitor
   int sl_mode = 0;
   int pd_c = 0, pl_c = 0;
   logic [7:0] rd_pat = '0;
   int rd_idx = 0, phase = 0, wait_c = 0, hold = 0;
   int cyc = 0, n_slot = 0;
   int lo_start [16];
   int lo_len [16];
   logic prev_oe = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (oe && !prev_oe) begin
         if (n_slot < 16) lo_start[n_slot] = cyc;
         if (sl_mode == 2 && rd_idx < 8) begin
            if (!rd_pat[rd_idx]) begin phase = 2; hold = 30 * CLK; end
            rd_idx++;
         end
      end
      if (!oe && prev_oe) begin
         if (n_slot < 16) lo_len[n_slot] = cyc - lo_start[n_slot];
         n_slot++;
         if (sl_mode == 1) begin phase = 1; wait_c = pd_c * CLK; hold = pl_c * CLK; end
      end
      case (phase)
         1: if (wait_c == 0) phase = 2; else wait_c--;
         2: if (hold == 0) phase = 0; else hold--;
         default: ;
      endcase
      slave_pull = (phase == 2);
      prev_oe = oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] k, input logic [7:0] b);
      @(negedge clk);
      cmd = k; wdata = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // returns cycles from the accepting edge to done, plus one
   task automatic wait_done(output int n);
      n = 1;
      while (!done && n < 20000) begin @(negedge clk); n++; end
      chk(done, "R6 done reached", int'(done), 1);
      @(negedge clk);
      chk(!done, "R7 done one cycle", int'(done), 0);
      while (phase != 0) @(negedge clk);
   endtask

   task automatic check_slots(input int kind, input logic [7:0] exp_b);
      logic [7:0] got;
      got = '0;
      chk(n_slot == 8, kind == 1 ? "R4 slot count" : "R5 slot count", n_slot, 8);
      for (int i = 0; i < 8; i++) begin
         if (kind == 1) begin
            chk(lo_len[i] == 5 * CLK || lo_len[i] == 60 * CLK, "R4 low time", lo_len[i], 5 * CLK);
            got[i] = (lo_len[i] == 5 * CLK);
         end else begin
            chk(lo_len[i] == 5 * CLK, "R5 low time", lo_len[i], 5 * CLK);
         end
         if (i > 0)
            chk(lo_start[i] - lo_start[i-1] == (kind == 1 ? 65 : 70) * CLK,
                kind == 1 ? "R4 slot period" : "R5 slot period",
                lo_start[i] - lo_start[i-1], (kind == 1 ? 65 : 70) * CLK);
      end
      if (kind == 1) chk(got == exp_b, "R4 byte on wire", int'(got), int'(exp_b));
   endtask

   task automatic prep(input int mode, input int pd, input int pl, input logic [7:0] pat);
      sl_mode = mode; pd_c = pd; pl_c = pl; rd_pat = pat; rd_idx = 0; n_slot = 0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(!busy, "R8 busy", int'(busy), 0);
      chk(!done, "R8 done", int'(done), 0);
      chk(!oe, "R8 oe", int'(oe), 0);
      chk(!present, "R8 present", int'(present), 0);
      chk(rdata == 8'h00, "R8 rdata", int'(rdata), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         t = VECS[v];
         if (t.kind == 2'd0) begin
            prep(t.has ? 1 : 0, int'(t.pd), int'(t.pl), 8'h00);
            issue(2'b00, 8'h00);
            wait_done(n);
            chk(n_slot == 1 && lo_len[0] == 500 * CLK, "R1 reset low time", lo_len[0], 500 * CLK);
            chk(present == t.exp, t.has ? "R3 presence" : "R2 presence", int'(present), int'(t.exp));
            if (!t.has) chk(n == 1000 * CLK + 1, "R2 absent timing", n, 1000 * CLK + 1);
         end else if (t.kind == 2'd1) begin
            prep(0, 0, 0, 8'h00);
            issue(2'b01, t.byt);
            wait_done(n);
            check_slots(1, t.byt);
         end else begin
            prep(2, 0, 0, t.byt);
            issue(2'b10, 8'h00);
            wait_done(n);
            check_slots(2, t.byt);
            chk(rdata == t.byt, "R5 read byte", int'(rdata), int'(t.byt));
         end
      end

      // R6: start during a write is ignored
      prep(0, 0, 0, 8'h00);
      issue(2'b01, 8'h5A);
      repeat (20) @(negedge clk);
      cmd = 2'b00; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(n);
      check_slots(1, 8'h5A);
      chk(n_slot == 8 && lo_len[0] != 500 * CLK, "R6 busy start ignored", lo_len[0], 5 * CLK);

      // R6: reserved code starts nothing
      prep(0, 0, 0, 8'h00);
      issue(2'b11, 8'h00);
      repeat (4) @(negedge clk);
      chk(!busy && !oe && n_slot == 0, "R6 reserved code", int'(busy), 0);

      // R7: read result survives a write and a reset
      prep(2, 0, 0, 8'h96);
      issue(2'b10, 8'h00);
      wait_done(n);
      chk(rdata == 8'h96, "R5 read byte 96", int'(rdata), 8'h96);
      prep(0, 0, 0, 8'h00);
      issue(2'b01, 8'hFF);
      wait_done(n);
      chk(rdata == 8'h96, "R7 rdata after write", int'(rdata), 8'h96);
      prep(1, 30, 120, 8'h00);
      issue(2'b00, 8'h00);
      wait_done(n);
      chk(present && rdata == 8'h96, "R7 rdata after reset", int'(rdata), 8'h96);
      prep(2, 0, 0, 8'h00);
      issue(2'b10, 8'h00);
      wait_done(n);
      chk(rdata == 8'h00, "R5 read byte 00", int'(rdata), 0);
      chk(present, "R7 present after read", int'(present), 1);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule